// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh Scheduler

This block keeps every row of an asynchronous DRAM with 512 rows refreshed inside the 8 ms retention window. It does not generate a row address. It issues CAS-before-RAS cycles, and the device's internal refresh counter chooses the row. A prescaled timer adds one refresh credit every 15.6 us. The exact interval is computed from the clock frequency parameter. While any credit is outstanding, the block raises a request to the access controller that normally owns the strobes.

After the controller grants the bus, the scheduler drives RAS and both byte-lane CAS strobes. It runs one CBR cycle per outstanding credit, back to back, with every phase length derived from nanosecond parameters. It then parks the strobes high, lets go of the bus and pulses done for one cycle. Write enable is held high throughout, and the block never touches the data bus.

The credit counter saturates. If the controller holds off the grant for several intervals, the missed refreshes are caught up in a single burst once the grant arrives.

Top module: `dram_cbr_refresh`

## Requirements
- R1: One refresh credit is added every INTERVAL clock cycles, where INTERVAL = floor((window_us*1000/rows) * clk_khz / 1e6). With the defaults of 8000 us, 512 rows and 125000 kHz, INTERVAL is 1953 cycles, so successive requests (each serviced at once) rise exactly 1953 cycles apart.
- R2: The request goes high whenever credits are pending and the block is idle, and it stays high until the cycle in which done is asserted. `bus_own` is asserted only after the grant has been sampled high.
- R3: While the block owns the bus, RAS is high for at least 10 ns before the CAS strobes fall. Both CAS strobes are low for at least 5 ns before RAS falls.
- R4: CAS stays low for at least 7 ns after RAS falls, and it returns high while RAS is still low.
- R5: RAS stays low for at least 25 ns. RAS then stays high for at least 15 ns before the next CAS fall, or before done. The time from one RAS fall to the next (or to done) is at least 43 ns.
- R6: `cas_lo_n` and `cas_hi_n` are always equal, and `we_n` is always 1.
- R7: The pending-credit count saturates at 8. A granted burst contains exactly min(credits accrued, 8) RAS falls.
- R8: Done is a pulse exactly one cycle wide. In that cycle RAS and both CAS strobes are high, `bus_own` is 0 and the request is 0.
- R9: While the grant is low, `bus_own` is 0 and RAS and both CAS strobes stay high.
- R10: During and directly after reset, the request, done and `bus_own` are 0, and all strobes and `we_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_req | output | 1 | Refresh request to the access controller |
| ref_gnt | input | 1 | Grant from the controller; held until done |
| ref_done | output | 1 | One-cycle pulse when the burst ends and the strobes are parked |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower byte column strobe, active low |
| cas_hi_n | output | 1 | Upper byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| bus_own | output | 1 | High while the scheduler drives the strobes |

## Verification
The bench serves requests at once, which shows whether the credit timer period is exact. It also withholds the grant for 1, 3, 8 and 11 intervals. These cases separate a correct credit count from one that loses credits, wraps past the limit or stops short of saturation. A monitor checks every owned cycle. It measures each strobe phase in nanoseconds and compares it with the minimum windows, which exposes any shortened setup, hold, pulse or precharge phase. Bursts of different lengths show whether the recovery phase between back-to-back cycles is honoured as well as the final one before done.

// File: rtl/dram_cbr_pkg.sv
package dram_cbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASK,
        ST_PARK,
        ST_CAS_LEAD,
        ST_ROW_LOW,
        ST_RECOVER,
        ST_FINISH
    } cbr_state_e;

    typedef struct packed {
        logic row_n;
        logic col_n;
        logic own;
        logic ask;
        logic fin;
    } cbr_drive_t;

    // Round a duration in ns up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_khz);
        longint prod;
        int     cyc;
        prod = longint'(ns) * longint'(clk_khz);
        cyc  = int'((prod + 64'd999999) / 64'd1000000);
        return (cyc < 1) ? 1 : cyc;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Cycles between refresh credits: the retention window split evenly over rows.
    function automatic int credit_interval(input int window_us, input int rows, input int clk_khz);
        longint step_ns;
        step_ns = longint'(window_us) * 64'd1000 / longint'(rows);
        return int'(step_ns * longint'(clk_khz) / 64'd1000000);
    endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
    parameter int INTERVAL = 1953
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);

    generate
        if (INTERVAL > 1) begin : g_spacing
            p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/cbr_pending_ctr.sv
module cbr_pending_ctr #(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic add,
    input  logic take,
    output logic nonzero
);
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] CAP = PW'(PEND_MAX);

    logic [PW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case ({add, take})
                2'b10:   if (count != CAP) count <= count + 1'b1;
                2'b01:   if (count != '0)  count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign nonzero = (count != '0);

    p_cap_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);
    p_take_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        take |-> count != '0);
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == CAP && count != CAP) |-> $past(take));

endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
    import dram_cbr_pkg::*;
#(
    parameter int PARK_CYC  = 2,
    parameter int LEAD_CYC  = 1,
    parameter int HOLD_CYC  = 1,
    parameter int ROW_CYC   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic gnt,
    output logic take,
    output cbr_drive_t drv
);
    localparam int MAXC = imax(imax(PARK_CYC, LEAD_CYC), ROW_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PARK_LD = CW'(PARK_CYC - 1);
    localparam logic [CW-1:0] LEAD_LD = CW'(LEAD_CYC - 1);
    localparam logic [CW-1:0] ROW_LD  = CW'(ROW_CYC - 1);
    localparam logic [CW-1:0] HOLD_TH = CW'(ROW_CYC - HOLD_CYC);

    cbr_state_e    st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          cnt_end;

    assign cnt_end = (cnt == '0);

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt_end ? cnt : cnt - 1'b1;
        case (st)
            ST_IDLE:     if (pending) st_nx = ST_ASK;
            ST_ASK:      if (gnt) begin st_nx = ST_PARK; cnt_nx = PARK_LD; end
            ST_PARK:     if (cnt_end) begin st_nx = ST_CAS_LEAD; cnt_nx = LEAD_LD; end
            ST_CAS_LEAD: if (cnt_end) begin st_nx = ST_ROW_LOW; cnt_nx = ROW_LD; end
            ST_ROW_LOW:  if (cnt_end) begin st_nx = ST_RECOVER; cnt_nx = PARK_LD; end
            ST_RECOVER: begin
                if (cnt_end) begin
                    if (pending) begin
                        st_nx  = ST_CAS_LEAD;
                        cnt_nx = LEAD_LD;
                    end else begin
                        st_nx = ST_FINISH;
                    end
                end
            end
            ST_FINISH:   st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        drv.row_n = (st != ST_ROW_LOW);
        drv.col_n = !((st == ST_CAS_LEAD) || (st == ST_ROW_LOW && cnt >= HOLD_TH));
        drv.own   = (st == ST_PARK) || (st == ST_CAS_LEAD) ||
                    (st == ST_ROW_LOW) || (st == ST_RECOVER);
        drv.ask   = drv.own || (st == ST_ASK);
        drv.fin   = (st == ST_FINISH);
    end

    assign take = (st == ST_ROW_LOW) && cnt_end;

    p_grant_first_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.own) |-> $past(gnt));
    p_cas_setup_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(drv.row_n) |-> (!drv.col_n && $past(!drv.col_n)));
    p_cas_release_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(drv.col_n) && drv.own) |-> !drv.row_n);
    p_ras_rise_cas_high_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.row_n) |-> drv.col_n);
    p_done_parked_r8: assert property (@(posedge clk) disable iff (rst)
        drv.fin |-> (drv.row_n && drv.col_n && !drv.own && !drv.ask));
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        drv.fin |=> !drv.fin);

endmodule

// File: rtl/dram_cbr_refresh.sv
module dram_cbr_refresh
    import dram_cbr_pkg::*;
#(
    parameter int CLK_KHZ   = 125000,
    parameter int ROWS      = 512,
    parameter int WINDOW_US = 8000,
    parameter int PEND_MAX  = 8,
    parameter int T_RPC_NS  = 10,
    parameter int T_CSR_NS  = 5,
    parameter int T_CHR_NS  = 7,
    parameter int T_RAS_NS  = 25,
    parameter int T_RC_NS   = 43,
    parameter int T_RP_NS   = 15
) (
    input  logic clk,
    input  logic rst,
    output logic ref_req,
    input  logic ref_gnt,
    output logic ref_done,
    output logic ras_n,
    output logic cas_lo_n,
    output logic cas_hi_n,
    output logic we_n,
    output logic bus_own
);
    localparam int INTERVAL = credit_interval(WINDOW_US, ROWS, CLK_KHZ);
    localparam int LEAD_CYC = ns_to_cyc(T_CSR_NS, CLK_KHZ);
    localparam int HOLD_CYC = ns_to_cyc(T_CHR_NS, CLK_KHZ);
    localparam int PARK_CYC = imax(ns_to_cyc(T_RP_NS, CLK_KHZ), ns_to_cyc(T_RPC_NS, CLK_KHZ));
    localparam int ROW_CYC  = imax(imax(ns_to_cyc(T_RAS_NS, CLK_KHZ), HOLD_CYC + 1),
                                   ns_to_cyc(T_RC_NS, CLK_KHZ) - PARK_CYC);

    logic       tick;
    logic       pending;
    logic       take;
    cbr_drive_t drv;

    cbr_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    cbr_pending_ctr #(.PEND_MAX(PEND_MAX)) u_pending (
        .clk     (clk),
        .rst     (rst),
        .add     (tick),
        .take    (take),
        .nonzero (pending)
    );

    cbr_sequencer #(
        .PARK_CYC (PARK_CYC),
        .LEAD_CYC (LEAD_CYC),
        .HOLD_CYC (HOLD_CYC),
        .ROW_CYC  (ROW_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .gnt     (ref_gnt),
        .take    (take),
        .drv     (drv)
    );

    assign ref_req  = drv.ask;
    assign ref_done = drv.fin;
    assign ras_n    = drv.row_n;
    assign cas_lo_n = drv.col_n;
    assign cas_hi_n = drv.col_n;
    assign we_n     = 1'b1;
    assign bus_own  = drv.own;

    p_req_held_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_req) |-> ref_done);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!ref_gnt && !bus_own) |-> (ras_n && cas_lo_n && cas_hi_n));

endmodule

// File: tb/dram_cbr_refresh_tb.sv
module dram_cbr_refresh_tb;
    localparam int PERIOD_NS    = 8;
    localparam int EXP_INTERVAL = (8000 * 1000 / 512) * 125 / 1000;
    localparam int WATCHDOG     = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, ref_done, ras_n, cas_lo_n, cas_hi_n, we_n, bus_own;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dram_cbr_refresh u_dut (
        .clk      (clk),
        .rst      (rst),
        .ref_req  (ref_req),
        .ref_gnt  (ref_gnt),
        .ref_done (ref_done),
        .ras_n    (ras_n),
        .cas_lo_n (cas_lo_n),
        .cas_hi_n (cas_hi_n),
        .we_n     (we_n),
        .bus_own  (bus_own)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor state
    logic prev_ras = 1, prev_cas = 1, prev_req = 0, prev_done = 0;
    int pre_run = 0, lead_run = 0, lo_run = 0, hold_run = 0, last_lo = 0;
    int since_fall = 0;
    bit seen_rise = 0;
    int falls = 0;
    int bad_pair = 0, idle_bad = 0, req_drop = 0;
    int rise_t = 0, prev_rise_t = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (cas_lo_n !== cas_hi_n || we_n !== 1'b1) bad_pair++;           // R6
            if (!ref_gnt && (bus_own || !ras_n || !cas_lo_n)) idle_bad++;    // R9
            if (prev_req && !ref_req && !ref_done) req_drop++;               // R2
            if (ref_req && !prev_req) begin
                prev_rise_t = rise_t;
                rise_t = cyc;
            end
            since_fall++;
            if (bus_own) begin
                if (ras_n && cas_lo_n) pre_run++;
                if (prev_cas && !cas_lo_n && ras_n) begin
                    chk(pre_run * PERIOD_NS >= 10, "R3 ras high before cas fall", pre_run * PERIOD_NS, 10);
                    if (seen_rise)
                        chk(pre_run * PERIOD_NS >= 15, "R5 ras precharge", pre_run * PERIOD_NS, 15);
                    pre_run = 0;
                    lead_run = 0;
                end
                if (!cas_lo_n && ras_n) lead_run++;
                if (prev_ras && !ras_n) begin
                    chk(!cas_lo_n, "R4 cas low at ras fall", cas_lo_n, 0);
                    chk(lead_run * PERIOD_NS >= 5, "R3 cas setup", lead_run * PERIOD_NS, 5);
                    if (seen_rise)
                        chk(since_fall * PERIOD_NS >= 43, "R5 row cycle", since_fall * PERIOD_NS, 43);
                    falls++;
                    since_fall = 0;
                    lo_run = 0;
                    hold_run = 0;
                    pre_run = 0;
                end
                if (!ras_n) begin
                    lo_run++;
                    if (!cas_lo_n) hold_run++;
                    if (!prev_cas && cas_lo_n)
                        chk(hold_run * PERIOD_NS >= 7, "R4 cas hold", hold_run * PERIOD_NS, 7);
                end
                if (!prev_ras && ras_n) begin
                    chk(lo_run * PERIOD_NS >= 25, "R5 ras low width", lo_run * PERIOD_NS, 25);
                    chk(cas_lo_n, "R4 cas released before ras rise", cas_lo_n, 1);
                    last_lo = lo_run;
                    seen_rise = 1;
                    pre_run = 1;
                end
            end
            if (ref_done) begin
                chk(ras_n && cas_lo_n && cas_hi_n && !bus_own && !ref_req,
                    "R8 parked at done", {ras_n, cas_lo_n, cas_hi_n, bus_own, ref_req}, 5'b11100);
                chk(!prev_done, "R8 done one cycle", prev_done, 0);
                chk(pre_run * PERIOD_NS >= 15, "R5 final precharge", pre_run * PERIOD_NS, 15);
                chk((last_lo + pre_run) * PERIOD_NS >= 43, "R5 final row cycle",
                    (last_lo + pre_run) * PERIOD_NS, 43);
                seen_rise = 0;
                pre_run = 0;
            end
            prev_ras  = ras_n;
            prev_cas  = cas_lo_n;
            prev_req  = ref_req;
            prev_done = ref_done;
        end
    end

    task automatic wait_req();
        int n = 0;
        while (!ref_req && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic serve(input int exp_falls, input string tag);
        int start;
        int n = 0;
        wait_req();
        start = falls;
        #1 ref_gnt = 1'b1;
        @(negedge clk);
        while (!ref_done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        #1 ref_gnt = 1'b0;
        chk(falls - start == exp_falls, tag, falls - start, exp_falls);
        @(negedge clk);
        chk(!ref_done, "R8 done low after pulse", ref_done, 0);
    endtask

    task automatic withhold(input int k);
        wait_req();
        repeat ((k - 1) * EXP_INTERVAL + 20) @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(!ref_req && !ref_done && !bus_own && ras_n && cas_lo_n && cas_hi_n && we_n,
            "R10 state in reset", {ref_req, ref_done, bus_own}, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!ref_req && !ref_done && !bus_own && ras_n && cas_lo_n && cas_hi_n && we_n,
            "R10 state after reset", {ref_req, ref_done, bus_own}, 0);

        serve(1, "R2 single grant gives one cycle");
        serve(1, "R7 one credit one cycle");
        chk(rise_t - prev_rise_t == EXP_INTERVAL, "R1 credit interval",
            rise_t - prev_rise_t, EXP_INTERVAL);

        withhold(3);
        serve(3, "R7 three deferred credits");
        withhold(8);
        serve(8, "R7 eight deferred credits");
        withhold(11);
        serve(8, "R7 saturation at eight");

        chk(bad_pair == 0, "R6 cas pair equal and we high", bad_pair, 0);
        chk(idle_bad == 0, "R9 quiet without grant", idle_bad, 0);
        chk(req_drop == 0, "R2 request held until done", req_drop, 0);
        finish_run();
    end

endmodule